// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block collects interrupt requests for a small CPU core. Two external request pins are synchronised and sensed according to a per-pin mode. The modes are low level, any change, falling edge and rising edge. In the edge and change modes a detected event is stored in a flag register. In level mode the flag is held at zero, and the request follows the pin directly. Seven timer request lines arrive already flagged by their timers. Each of them is gated by a bit of a timer mask register.

Every source is qualified by its own enable bit and by the core's global interrupt enable. The lowest pending vector number is latched onto a request/vector output pair. That pair is held until the core pulses the acknowledge input. The acknowledge also clears the flag of an external source that is in edge or change mode.

Four byte-wide registers are reached through a simple write strobe with a two-bit address. Reads return registered data one cycle after the address is presented.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and `irq_o` is low.
- R2: The flag register at address 0 keeps the pin-1 flag in bit 7 and the pin-0 flag in bit 6. Bits 5..0 always read zero, and writes to them have no effect.
- R3: The sense field for pin n is bits [2n+1:2n] of the register at address 3. The codes are 00 = low level, 01 = any change, 10 = falling edge and 11 = rising edge. In codes 01/10/11 the selected pin event sets the flag, and the flag can be read three clock edges after the pin changes. Any other event leaves the flag unchanged.
- R4: With sense code 00 the pin's flag reads zero. A low pin raises that source's request after the two synchroniser stages.
- R5: In edge or change mode, acknowledging vector 1 clears the pin-0 flag and acknowledging vector 2 clears the pin-1 flag.
- R6: Writing a one to a flag bit at address 0 clears that flag. Writing a zero leaves the flag unchanged.
- R7: A source is requested only when `gie_i` is high and the source's enable bit is set. The external enables are at address 1, with bit 6 for pin 0 and bit 7 for pin 1. Bits 5..0 of address 1 read zero.
- R8: The timer mask register is at address 2, and bit 1 reads zero. Timer line k (0..6) uses vector k+3 and is gated by mask bit 7-k for k<5, by bit 2 for k=5, and by bit 0 for k=6.
- R9: Once `irq_o` is high, `irq_vec_o` stays unchanged until `ack_i`. On the edge that samples `ack_i`, `irq_o` drops.
- R10: When several enabled requests are pending, the lowest vector wins. Pin 0 is vector 1 and pin 1 is vector 2. A new request is presented one edge after it becomes pending while `irq_o` is low.
- R11: The sense register at address 3 keeps bits 3..0, and its bits 7..4 read zero. Read data appears on the edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie_i | input | 1 | Global interrupt enable from the core |
| pin_i | input | 2 | Asynchronous external request pins |
| tmr_flag_i | input | 7 | Timer request flags, line k maps to vector k+3 |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| ack_i | input | 1 | Acknowledge of the presented vector |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 4 | Vector number of the presented request |

## Verification
A pin change reaches the flag on the third rising edge, because it passes two synchroniser stages and then the flag update. The request output follows one edge later. A register read is valid on the edge after the address is presented. The bench drives inputs on the falling edge and waits exactly those edge counts before it samples on a falling edge. In the random timer phase, a reference model is advanced once per cycle from the inputs that were applied before each rising edge. The request and vector are compared on the following falling edge.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int NUM_PINS = 2;
  localparam int NUM_TMR  = 7;
  localparam int NUM_SRC  = NUM_PINS + NUM_TMR;
  localparam int VEC_W    = 4;
  localparam int DATA_W   = 8;
  localparam int FLAG_LSB = 6;

  localparam logic [1:0] ADR_FLAG  = 2'd0;
  localparam logic [1:0] ADR_EXTEN = 2'd1;
  localparam logic [1:0] ADR_TMASK = 2'd2;
  localparam logic [1:0] ADR_SENSE = 2'd3;

  localparam logic [DATA_W-1:0] TMASK_RW = 8'hFD;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  function automatic int tmask_bit(input int k);
    if (k < 5) return 7 - k;
    else if (k == 5) return 2;
    else return 0;
  endfunction
endpackage

// File: rtl/eirq_pin_sense.sv
module eirq_pin_sense
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   pin_i,
  input  sense_e mode_i,
  output logic   evt_o,
  output logic   lvl_req_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  always_comb begin
    unique case (mode_i)
      SNS_ANY:  evt_o = cur ^ prev_q;
      SNS_FALL: evt_o = prev_q & ~cur;
      SNS_RISE: evt_o = ~prev_q & cur;
      default:  evt_o = 1'b0;
    endcase
    lvl_req_o = (mode_i == SNS_LOW) & ~cur;
  end
endmodule

// File: rtl/eirq_arbiter.sv
module eirq_arbiter #(
  parameter int NSRC  = 9,
  parameter int VEC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  req_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [VEC_W-1:0] sel;
  logic             found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && !found) begin
        sel   = VEC_W'(i + 1);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else if (irq_o) begin
      if (ack_i) irq_o <= 1'b0;
    end else if (found) begin
      irq_o <= 1'b1;
      vec_o <= sel;
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gie_i,
  input  logic [1:0]        pin_i,
  input  logic [6:0]        tmr_flag_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [3:0]        irq_vec_o
);
  localparam int SNS_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] flag_q, exten_q, evt, lvl;
  logic [DATA_W-1:0]   tmask_q;
  logic [SNS_W-1:0]    sense_q;
  logic [NUM_SRC-1:0]  req;
  logic                wr_flag;

  assign wr_flag = reg_wr_i && (reg_addr_i == ADR_FLAG);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    eirq_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk       (clk),
      .rst       (rst),
      .pin_i     (pin_i[g]),
      .mode_i    (sense_e'(sense_q[2*g +: 2])),
      .evt_o     (evt[g]),
      .lvl_req_o (lvl[g])
    );

    always_ff @(posedge clk) begin
      if (rst)
        flag_q[g] <= 1'b0;
      else if (sense_e'(sense_q[2*g +: 2]) == SNS_LOW)
        flag_q[g] <= 1'b0;
      else if (evt[g])
        flag_q[g] <= 1'b1;
      else if (wr_flag && reg_wdata_i[FLAG_LSB + g])
        flag_q[g] <= 1'b0;
      else if (irq_o && ack_i && irq_vec_o == VEC_W'(g + 1))
        flag_q[g] <= 1'b0;
    end

    assign req[g] = gie_i & exten_q[g] & (flag_q[g] | lvl[g]);
  end

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    assign req[NUM_PINS + k] = gie_i & tmask_q[tmask_bit(k)] & tmr_flag_i[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exten_q <= '0;
      tmask_q <= '0;
      sense_q <= '0;
    end else if (reg_wr_i) begin
      unique case (reg_addr_i)
        ADR_EXTEN: exten_q <= reg_wdata_i[FLAG_LSB +: NUM_PINS];
        ADR_TMASK: tmask_q <= reg_wdata_i & TMASK_RW;
        ADR_SENSE: sense_q <= reg_wdata_i[SNS_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata_o <= '0;
    else begin
      unique case (reg_addr_i)
        ADR_FLAG:  reg_rdata_o <= {flag_q, {FLAG_LSB{1'b0}}};
        ADR_EXTEN: reg_rdata_o <= {exten_q, {FLAG_LSB{1'b0}}};
        ADR_TMASK: reg_rdata_o <= tmask_q;
        default:   reg_rdata_o <= {{(DATA_W-SNS_W){1'b0}}, sense_q};
      endcase
    end
  end

  eirq_arbiter #(.NSRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req_i (req),
    .ack_i (ack_i),
    .irq_o (irq_o),
    .vec_o (irq_vec_o)
  );
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker (
  input logic       clk,
  input logic       rst,
  input logic       gie_i,
  input logic       ack_i,
  input logic       irq_o,
  input logic [3:0] irq_vec_o,
  input logic       reg_wr_i,
  input logic [1:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [1:0] flag_q,
  input logic [3:0] sense_q,
  input logic [1:0] evt
);
  AST_LEVEL_FLAG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sense_q[1:0] == 2'b00) |=> !flag_q[0]); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == 2'd0 && reg_wdata_i[6] && !evt[0]) |=> !flag_q[0]); // R6

  AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i && irq_vec_o == 4'd2 && !evt[1]) |=> !flag_q[1]); // R5

  AST_NO_GIE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!gie_i && !irq_o) |=> !irq_o); // R7

  AST_HOLD_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i) |=> (irq_o && $stable(irq_vec_o))); // R9

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i) |=> !irq_o); // R9

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (irq_vec_o >= 4'd1 && irq_vec_o <= 4'd9)); // R8
endmodule

bind ext_irq_ctrl eirq_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .gie_i       (gie_i),
  .ack_i       (ack_i),
  .irq_o       (irq_o),
  .irq_vec_o   (irq_vec_o),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .flag_q      (flag_q),
  .sense_q     (sense_q),
  .evt         (evt)
);

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gie_i = 1'b0;
  logic [1:0] pin_i = 2'b11;
  logic [6:0] tmr_flag_i = '0;
  logic [1:0] reg_addr_i = '0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       ack_i = 1'b0;
  logic       irq_o;
  logic [3:0] irq_vec_o;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  logic [7:0] rv;
  logic       m_irq;
  logic [3:0] m_vec;
  logic [7:0] m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl u0 (
    .clk(clk), .rst(rst), .gie_i(gie_i), .pin_i(pin_i), .tmr_flag_i(tmr_flag_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .ack_i(ack_i), .irq_o(irq_o), .irq_vec_o(irq_vec_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    tick(1);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    tick(1);
    d = reg_rdata_o;
  endtask

  task automatic ack_pulse();
    ack_i = 1'b1;
    tick(1);
    ack_i = 1'b0;
  endtask

  function automatic int mask_bit(input int k);
    return (k < 5) ? 7 - k : ((k == 5) ? 2 : 0);
  endfunction

  // Reference for the timer path: lowest enabled pending line gives vector k+3
  function automatic int lowest_vec(input logic [7:0] mask, input logic [6:0] tf, input logic g);
    for (int k = 0; k < 7; k++)
      if (g && mask[mask_bit(k)] && tf[k]) return k + 3;
    return 0;
  endfunction

  task automatic random_phase(input int cycles, input string tag);
    int v;
    for (int c = 0; c < cycles; c++) begin
      tmr_flag_i = 7'($urandom);
      gie_i = ($urandom % 5) != 0;
      ack_i = m_irq && (($urandom % 3) == 0);
      v = lowest_vec(m_mask, tmr_flag_i, gie_i);
      if (m_irq) begin
        if (ack_i) m_irq = 1'b0;
      end else if (v != 0) begin
        m_irq = 1'b1;
        m_vec = 4'(v);
      end
      tick(1);
      check({tag, " irq"}, irq_o, m_irq);
      if (m_irq) check({tag, " vector"}, irq_vec_o, m_vec);
    end
    ack_i = 1'b0;
    tmr_flag_i = '0;
    gie_i = 1'b0;
    if (m_irq) ack_pulse();
    m_irq = 1'b0;
    tick(1);
    check("R9 drained", irq_o, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1 irq", irq_o, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), rv);
      check("R1 reg", rv, 0);
    end
    // R8, R11, R7, R2 register layout
    wr(2'd2, 8'hFF); rd(2'd2, rv); check("R8 tmask rsvd bit1", rv, 8'hFD);
    wr(2'd1, 8'hFF); rd(2'd1, rv); check("R7 exten layout", rv, 8'hC0);
    wr(2'd3, 8'hFF); rd(2'd3, rv); check("R11 sense layout", rv, 8'h0F);
    wr(2'd0, 8'hFF); rd(2'd0, rv); check("R2 flag rsvd", rv, 8'h00);
    // R3 falling edge on pin 0, any-change on pin 1
    wr(2'd3, 8'h06);
    pin_i[0] = 1'b0;
    tick(3);
    rd(2'd0, rv); check("R3 falling sets flag0", rv, 8'h40);
    check("R7 gie low no irq", irq_o, 0);
    wr(2'd0, 8'h40); rd(2'd0, rv); check("R6 write one clears", rv, 8'h00);
    pin_i[0] = 1'b1;
    tick(4);
    rd(2'd0, rv); check("R3 rising ignored in falling mode", rv, 8'h00);
    pin_i[0] = 1'b0;
    tick(3);
    wr(2'd0, 8'h00); rd(2'd0, rv); check("R6 write zero keeps", rv, 8'h40);
    pin_i[1] = 1'b0;
    tick(3);
    rd(2'd0, rv); check("R3 any change sets flag1", rv, 8'hC0);
    check("R7 still no irq", irq_o, 0);
    // R10 priority, R9 ack, R5 ack clears flags
    gie_i = 1'b1;
    tick(1);
    check("R10 irq", irq_o, 1);
    check("R10 lowest vector", irq_vec_o, 1);
    ack_pulse();
    check("R9 ack drops irq", irq_o, 0);
    tick(1);
    check("R10 next irq", irq_o, 1);
    check("R10 next vector", irq_vec_o, 2);
    rd(2'd0, rv); check("R5 ack clears flag0", rv, 8'h80);
    ack_pulse();
    tick(1);
    check("R9 idle after ack", irq_o, 0);
    rd(2'd0, rv); check("R5 ack clears flag1", rv, 8'h00);
    // R4 level mode on pin 0 (pin still low)
    wr(2'd3, 8'h04);
    tick(1);
    check("R4 level irq", irq_o, 1);
    check("R4 level vector", irq_vec_o, 1);
    rd(2'd0, rv); check("R4 level flag zero", rv, 8'h00);
    pin_i[0] = 1'b1;
    tick(3);
    ack_pulse();
    tick(1);
    check("R4 level released", irq_o, 0);
    rd(2'd0, rv); check("R4 flag zero after rise", rv, 8'h00);
    // Random timer phases: R8 R9 R10
    wr(2'd1, 8'h00);
    m_irq = 1'b0; m_vec = '0;
    m_mask = 8'hFD;
    random_phase(300, "R10 timer mask FF");
    wr(2'd2, 8'h58);
    rd(2'd2, rv); check("R8 tmask readback", rv, 8'h58);
    m_mask = 8'h58;
    random_phase(300, "R8 timer mask 58");
    wr(2'd2, 8'h07);
    m_mask = 8'h05;
    random_phase(200, "R8 timer mask low bits");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule